// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that retires one instruction on every clock edge. On each cycle it presents the program counter to an instruction port and takes the instruction word back in the same cycle. It decodes the word in two levels: a main controller driven by the opcode and an ALU controller driven by the function field. It reads two registers, computes in the ALU, reads or writes a separate data port when the instruction needs it, writes a result back, and selects the next program counter.

The instruction port is read combinationally. The data port exposes an address, write data, a write enable and a read enable. The memory behind it writes on the rising edge and returns read data combinationally. The core handles a fixed integer subset: register-register add, subtract, and, or, exclusive-or and signed set-less-than; their immediate forms; word load and store; equal and not-equal branches; and an absolute jump. Any other encoding retires as a no-op.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset loads the program counter with 0 on the next rising edge. While reset is high, the data write enable and read enable stay low.
- R2: An instruction with opcode 0 takes its operation from the function field (0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 exclusive-or). It uses operands rs=[25:21] and rt=[20:16] and writes rd=[15:11].
- R3: Immediate operations take imm=[15:0] and write rt. The opcodes are 0x08 add, 0x0A set-less-than, 0x0C and, 0x0D or and 0x0E exclusive-or. The immediate is zero-extended for and, or and exclusive-or, and sign-extended for add and set-less-than.
- R4: Register 0 always reads as zero, and a write addressed to it has no effect.
- R5: A load (opcode 0x23) drives the data address to rs + sign-extended imm and raises the read enable. It writes the returned word into rt.
- R6: The data write enable is high only for a store (opcode 0x2B). A store drives the address rs + sign-extended imm and the write data equal to the value of register rt.
- R7: An equal branch (0x04) or not-equal branch (0x05) compares rs with rt. When the branch is taken, the next PC is PC + 4 + 4 × sign-extended imm; otherwise it is PC + 4.
- R8: A jump (opcode 0x02) loads the PC with bits [31:28] of PC + 4, followed by imm26=[25:0] and then two zero bits.
- R9: An unrecognised opcode, or opcode 0 with an unlisted function code, writes no register and no memory and advances the PC by 4.
- R10: Every instruction that is not a taken branch or a jump advances the PC by exactly 4 per clock.
- R11: Set-less-than (function 0x2A and opcode 0x0A) compares as signed two's-complement values and produces exactly 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter presented to the instruction port |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data port byte address |
| dmem_wdata | output | 32 | Data port write data |
| dmem_wen | output | 1 | Data port write enable, written on the rising edge |
| dmem_ren | output | 1 | Data port read enable |
| dmem_rdata | input | 32 | Data port read data, same cycle |

## Verification
Register contents cannot be seen at the ports. The hardest situation to show is therefore a write that must not happen: to register 0, or from an unrecognised opcode or function code. The program first loads the would-be destination registers with known values and then issues the suspect words. Afterwards it stores every register out through the data port, so a write that should have been suppressed shows up in memory. A reference model steps alongside the core and checks the PC and every data-port transaction each cycle. The program takes and skips both branch kinds and includes a backward branch.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int DATA_W = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_ADD = 4'b0000,
    ALU_SUB = 4'b0010,
    ALU_AND = 4'b0100,
    ALU_OR  = 4'b0101,
    ALU_XOR = 4'b0110,
    ALU_SLT = 4'b1010
  } alu_code_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_FUNCT, CLS_ADD, CLS_SUB,
    CLS_AND, CLS_OR, CLS_XOR, CLS_SLT
  } alu_cls_e;

  typedef struct packed {
    logic dst_rd;
    logic reg_we;
    logic sext;
    logic src_imm;
    logic mem_rd;
    logic mem_wr;
    logic mem_to_reg;
    logic br_eq;
    logic br_ne;
    logic jmp;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ext_imm(input logic [15:0] imm, input logic sext);
    return {{(DATA_W-16){sext & imm[15]}}, imm};
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(input logic [3:0] code,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (code)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_XOR: r = a ^ b;
      ALU_SLT: r = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] branch_target(input logic [DATA_W-1:0] pc4,
                                                      input logic [15:0] imm);
    return pc4 + {{(DATA_W-18){imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] jump_target(input logic [DATA_W-1:0] pc4,
                                                    input logic [25:0] idx);
    return {pc4[DATA_W-1:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output logic [3:0] alu_code,
  output logic       bad_instr
);

  ctrl_t    raw;
  alu_cls_e cls;
  logic     op_ok;
  logic     funct_ok;

  // main controller: opcode to datapath controls
  always_comb begin
    raw   = '0;
    cls   = CLS_NONE;
    op_ok = 1'b1;
    case (op)
      OP_RTYPE: begin raw.dst_rd = 1'b1; raw.reg_we = 1'b1; cls = CLS_FUNCT; end
      OP_ADDI:  begin raw.reg_we = 1'b1; raw.sext = 1'b1; raw.src_imm = 1'b1; cls = CLS_ADD; end
      OP_SLTI:  begin raw.reg_we = 1'b1; raw.sext = 1'b1; raw.src_imm = 1'b1; cls = CLS_SLT; end
      OP_ANDI:  begin raw.reg_we = 1'b1; raw.src_imm = 1'b1; cls = CLS_AND; end
      OP_ORI:   begin raw.reg_we = 1'b1; raw.src_imm = 1'b1; cls = CLS_OR; end
      OP_XORI:  begin raw.reg_we = 1'b1; raw.src_imm = 1'b1; cls = CLS_XOR; end
      OP_LW: begin
        raw.reg_we = 1'b1; raw.sext = 1'b1; raw.src_imm = 1'b1;
        raw.mem_rd = 1'b1; raw.mem_to_reg = 1'b1; cls = CLS_ADD;
      end
      OP_SW: begin raw.sext = 1'b1; raw.src_imm = 1'b1; raw.mem_wr = 1'b1; cls = CLS_ADD; end
      OP_BEQ:   begin raw.br_eq = 1'b1; cls = CLS_SUB; end
      OP_BNE:   begin raw.br_ne = 1'b1; cls = CLS_SUB; end
      OP_J:     raw.jmp = 1'b1;
      default:  op_ok = 1'b0;
    endcase
  end

  // ALU controller: class plus function field to the 4-bit code
  always_comb begin
    funct_ok = 1'b0;
    alu_code = ALU_ADD;
    case (cls)
      CLS_FUNCT: begin
        case (funct)
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT: begin
            funct_ok = 1'b1;
            alu_code = funct[3:0];
          end
          default: funct_ok = 1'b0;
        endcase
      end
      CLS_SUB: alu_code = ALU_SUB;
      CLS_AND: alu_code = ALU_AND;
      CLS_OR:  alu_code = ALU_OR;
      CLS_XOR: alu_code = ALU_XOR;
      CLS_SLT: alu_code = ALU_SLT;
      default: alu_code = ALU_ADD;
    endcase
  end

  assign bad_instr = ~op_ok | ((cls == CLS_FUNCT) & ~funct_ok);

  always_comb begin
    ctl        = raw;
    ctl.reg_we = raw.reg_we & ~bad_instr;
  end

  always_comb begin
    if (bad_instr) begin
      // R9
      illegal_quiet_chk: assert (!ctl.reg_we && !ctl.mem_wr && !ctl.jmp && !ctl.br_eq && !ctl.br_ne);
    end
    if (ctl.mem_wr) begin
      // R6
      store_only_wr_chk: assert (op == OP_SW);
    end
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);

  assign y    = alu_eval(code, a, b);
  assign zero = (y == '0);

  always_comb begin
    if (code == ALU_SLT) begin
      // R11
      slt_boolean_chk: assert (y[W-1:1] == '0);
    end
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = DATA_W,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] wa,
  input  logic          we,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);

  logic [W-1:0] regs [1:NREG-1];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ra == '0) |-> (qa == '0));

  // R4
  zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rb == '0) |-> (qb == '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int NREG = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [DATA_W-1:0] imem_data,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_wen,
  output logic              dmem_ren,
  input  logic [DATA_W-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  logic [DATA_W-1:0] pc_q, pc_plus4, next_pc;
  logic [DATA_W-1:0] rs_val, rt_val, op_b, alu_y, rf_wd;
  logic [AW-1:0]     rs_f, rt_f, rd_f, rf_wa;
  logic [5:0]        op_f, fn_f;
  logic [15:0]       imm16;
  logic [25:0]       imm26;
  ctrl_t             ctl;
  logic [3:0]        alu_code;
  logic              bad_instr, alu_zero, rf_we;
  logic              take_branch, take_jump;

  assign op_f  = imem_data[31:26];
  assign rs_f  = imem_data[25:21];
  assign rt_f  = imem_data[20:16];
  assign rd_f  = imem_data[15:11];
  assign fn_f  = imem_data[5:0];
  assign imm16 = imem_data[15:0];
  assign imm26 = imem_data[25:0];

  sc_ctrl u_ctrl (
    .op        (op_f),
    .funct     (fn_f),
    .ctl       (ctl),
    .alu_code  (alu_code),
    .bad_instr (bad_instr)
  );

  assign rf_wa = ctl.dst_rd ? rd_f : rt_f;
  assign rf_we = ctl.reg_we & ~rst;
  assign rf_wd = ctl.mem_to_reg ? dmem_rdata : alu_y;

  sc_regfile #(.NREG(NREG), .W(DATA_W)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra  (rs_f),
    .rb  (rt_f),
    .wa  (rf_wa),
    .we  (rf_we),
    .wd  (rf_wd),
    .qa  (rs_val),
    .qb  (rt_val)
  );

  assign op_b = ctl.src_imm ? ext_imm(imm16, ctl.sext) : rt_val;

  sc_alu #(.W(DATA_W)) u_alu (
    .code (alu_code),
    .a    (rs_val),
    .b    (op_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_wen   = ctl.mem_wr & ~rst;
  assign dmem_ren   = ctl.mem_rd & ~rst;

  assign pc_plus4    = pc_q + DATA_W'(4);
  assign take_branch = (ctl.br_eq & alu_zero) | (ctl.br_ne & ~alu_zero);
  assign take_jump   = ctl.jmp;

  always_comb begin
    if (take_jump)        next_pc = jump_target(pc_plus4, imm26);
    else if (take_branch) next_pc = branch_target(pc_plus4, imm16);
    else                  next_pc = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= next_pc;
  end

  assign imem_addr = pc_q;

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (imem_addr == RESET_PC));

  // R10
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !take_jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7
  branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (take_branch && !take_jump) |=>
      (pc_q == $past(pc_q) + 32'd4 + $past({{14{imem_data[15]}}, imem_data[15:0], 2'b00})));

  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> (pc_q[27:0] == {$past(imem_data[25:0]), 2'b00}));

  // R5
  load_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (dmem_ren && rf_we) |-> (rf_wd == dmem_rdata));

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_wen, dmem_ren;

  always #2.5 clk = ~clk;

  sc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_wen   (dmem_wen),
    .dmem_ren   (dmem_ren),
    .dmem_rdata (dmem_rdata)
  );

  logic [31:0] imem [128];
  logic [31:0] dmem [64];

  assign imem_data  = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_wen) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] ei(int op, int rt, int rs, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] er(int fn, int rd, int rs, int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] ej(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  // words 0..20: arithmetic and logic block
  localparam logic [31:0] PROG_A [21] = '{
    ei(8'h08, 1, 0, 5),          // r1 = 5
    ei(8'h08, 2, 0, -3),         // r2 = -3 (R3 sign-extend)
    ei(8'h0D, 3, 0, 16'h8001),   // r3 = 0x8001 (R3 zero-extend)
    ei(8'h0C, 4, 2, 16'hF0F0),
    ei(8'h0E, 5, 2, 16'hFFFF),
    er(8'h20, 6, 1, 2),
    er(8'h22, 7, 1, 2),
    er(8'h24, 8, 3, 4),
    er(8'h25, 9, 1, 3),
    er(8'h26, 10, 4, 5),
    er(8'h2A, 11, 2, 1),         // R11 -3 < 5
    er(8'h2A, 12, 1, 2),
    ei(8'h0A, 13, 2, -2),
    ei(8'h0A, 14, 1, 5),
    ei(8'h08, 0, 0, 7),          // R4 write to r0
    er(8'h20, 15, 0, 1),
    ei(8'h08, 20, 0, 16'h11),
    ei(8'h08, 22, 0, 16'h22),
    ei(8'h08, 24, 0, 16'h44),
    ei(8'h08, 25, 0, 16'h55),
    ei(8'h08, 26, 0, 16'h66)
  };

  // words 37..52: loads, branches, bad encodings, jump
  localparam logic [31:0] PROG_B [16] = '{
    ei(8'h23, 16, 0, 8),
    ei(8'h23, 17, 1, 15),
    ei(8'h08, 18, 0, 64),
    ei(8'h23, 19, 18, -56),
    ei(8'h04, 15, 1, 1),         // taken
    ei(8'h08, 20, 0, 1),
    ei(8'h04, 2, 1, 1),          // not taken
    ei(8'h08, 21, 0, 2),
    ei(8'h05, 2, 1, 1),          // taken
    ei(8'h08, 22, 0, 3),
    ei(8'h05, 15, 1, 1),         // not taken
    ei(8'h08, 23, 0, 4),
    {6'h3F, 5'd1, 5'd24, 16'hFFFF},  // unknown opcode, rt = r24
    er(8'h21, 25, 1, 1),         // unknown funct, rd = r25
    ej(53),
    ei(8'h08, 26, 0, 9)
  };

  int    n_chk  = 0;
  int    n_fail = 0;
  logic [31:0] rpc;
  logic [31:0] rr [32];
  logic [31:0] rmem [64];
  string last_tag = "R1";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string word_tag(int k);
    if (k == 0 || k == 15) return "R4";
    if ((k >= 1 && k <= 5) || k == 13 || k == 14) return "R3";
    if (k >= 6 && k <= 10) return "R2";
    if (k == 11 || k == 12) return "R11";
    if (k >= 32 && k <= 35) return "R5";
    if (k >= 36 && k <= 39) return "R7";
    if (k == 40 || k == 41) return "R9";
    if (k == 42) return "R8";
    return "R6";
  endfunction

  // reference model: compare this cycle's ports, then advance one instruction
  task automatic step_check();
    logic [31:0] w, a, b, sx, zx, eaddr, ewd, npc, wval;
    logic        ewe, ere, bad;
    int          rsn, rtn, rdn, wdst;
    string       tag;
    w   = imem[rpc[8:2]];
    rsn = int'(w[25:21]); rtn = int'(w[20:16]); rdn = int'(w[15:11]);
    a   = (rsn == 0) ? 32'd0 : rr[rsn];
    b   = (rtn == 0) ? 32'd0 : rr[rtn];
    sx  = {{16{w[15]}}, w[15:0]};
    zx  = {16'd0, w[15:0]};
    ewe = 1'b0; ere = 1'b0; eaddr = '0; ewd = '0; bad = 1'b0;
    npc = rpc + 32'd4; wdst = 0; wval = '0; tag = "R10";
    case (w[31:26])
      6'h00: begin
        wdst = rdn;
        case (w[5:0])
          6'h20: wval = a + b;
          6'h22: wval = a - b;
          6'h24: wval = a & b;
          6'h25: wval = a | b;
          6'h26: wval = a ^ b;
          6'h2A: wval = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin wdst = 0; bad = 1'b1; tag = "R9"; end
        endcase
      end
      6'h08: begin wdst = rtn; wval = a + sx; end
      6'h0A: begin wdst = rtn; wval = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
      6'h0C: begin wdst = rtn; wval = a & zx; end
      6'h0D: begin wdst = rtn; wval = a | zx; end
      6'h0E: begin wdst = rtn; wval = a ^ zx; end
      6'h23: begin ere = 1'b1; eaddr = a + sx; wdst = rtn; wval = rmem[eaddr[7:2]]; end
      6'h2B: begin ewe = 1'b1; eaddr = a + sx; ewd = b; end
      6'h04: begin tag = "R7"; if (a == b) npc = rpc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h05: begin tag = "R7"; if (a != b) npc = rpc + 32'd4 + {sx[29:0], 2'b00}; end
      6'h02: begin tag = "R8"; npc = {npc[31:28], w[25:0], 2'b00}; end
      default: begin bad = 1'b1; tag = "R9"; end
    endcase
    chk(imem_addr === rpc, last_tag, imem_addr, rpc);
    chk(dmem_wen === ewe, bad ? "R9" : "R6", {31'd0, dmem_wen}, {31'd0, ewe});
    if (ewe) begin
      chk(dmem_addr === eaddr, "R6", dmem_addr, eaddr);
      chk(dmem_wdata === ewd, "R6", dmem_wdata, ewd);
    end
    chk(dmem_ren === ere, "R5", {31'd0, dmem_ren}, {31'd0, ere});
    if (ere) chk(dmem_addr === eaddr, "R5", dmem_addr, eaddr);
    if (wdst != 0) rr[wdst] = wval;
    if (ewe) rmem[eaddr[7:2]] = ewd;
    rpc = npc;
    last_tag = tag;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) imem[i] = 32'd0;
    for (int i = 0; i < 64; i++) begin dmem[i] = 32'd0; rmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) rr[i] = 32'd0;
    for (int i = 0; i < 65; i++) begin
      if (i < 21)      imem[i] = PROG_A[i];
      else if (i < 37) imem[i] = ei(8'h2B, i - 21, 0, 4 * (i - 21));
      else if (i < 53) imem[i] = PROG_B[i - 37];
      else if (i < 64) imem[i] = ei(8'h2B, i - 37, 0, 4 * (i - 21));
      else             imem[i] = ei(8'h04, 0, 0, -1);   // backward branch to itself
    end
    rpc = 32'd0;

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(imem_addr === 32'd0, "R1", imem_addr, 32'd0);
    chk(dmem_wen === 1'b0, "R1", {31'd0, dmem_wen}, 32'd0);
    chk(dmem_ren === 1'b0, "R1", {31'd0, dmem_ren}, 32'd0);
    rst = 1'b0;
    #1;
    for (int c = 0; c < 90; c++) begin
      step_check();
      @(negedge clk);
    end

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(imem_addr === 32'd0, "R1", imem_addr, 32'd0);
    chk(dmem_wen === 1'b0, "R1", {31'd0, dmem_wen}, 32'd0);
    rst = 1'b0;
    rpc = 32'd0;
    last_tag = "R1";
    #1;
    for (int c = 0; c < 3; c++) begin
      step_check();
      @(negedge clk);
    end

    // stored register images
    for (int k = 0; k < 64; k++) begin
      chk(dmem[k] === rmem[k], word_tag(k), dmem[k], rmem[k]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule